// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the chip last went through reset. Seven hardware sources can each report a reset event with a one-cycle pulse: option-byte reload, the external reset pin, brown-out, a software reset request, the independent watchdog, the window watchdog, and an illegal entry into a low-power mode. Each pulse sets its own sticky flag. The flag stays set until software clears it. The flag storage is reset only by the power-on domain reset. The system resets that the flags record do not clear them.

Software reads the flags over a simple register bus. It clears all seven flags at once by writing 1 to a self-clearing command bit. A configuration input can mark that command bit as secure. A non-secure access to a secured bit then reads zero, and its write is dropped without any error indication. Two further configuration inputs can require privilege for the command bit. One applies while the bit is secure and the other applies while it is non-secure.

Top module: `rst_cause_reg`

## Requirements
- R1: After `por_rst_n` is asserted, all seven flags are 0, and a read returns 0x00000000.
- R2: A pulse on `src_pulse[i]` sets flag i. The flag is visible at read bit 25+i from the cycle after the pulse. The index order is: 0 option-byte reload, 1 pin, 2 brown-out, 3 software, 4 independent watchdog, 5 window watchdog, 6 low-power entry.
- R3: An accepted write with bit 23 = 1 clears all seven flags, and the read in the next cycle shows them at 0. A write with bit 23 = 0 changes no flag.
- R4: Flags are sticky. A pulse that arrives in the same cycle as an accepted clear leaves its flag set.
- R5: While `cfg_cmd_secure` = 1, a write of bit 23 = 1 with `bus_secure` = 0 is ignored and every flag keeps its value.
- R6: While `cfg_cmd_secure` = 1 and `cfg_priv_sec` = 1, a secure write of bit 23 = 1 with `bus_priv` = 0 is ignored. While `cfg_cmd_secure` = 0 and `cfg_priv_nsec` = 1, an unprivileged write of bit 23 = 1 is ignored. A privileged write is accepted in both cases.
- R7: Read bits 0 to 22 and bit 24 always read 0. Bit 23 reads 0, because the command bit clears itself. The flag bits are readable by every access, whatever its security or privilege.
- R8: A read in the same cycle as an accepted clear returns the flags as they were before the clear. `bus_rdata` is 0 whenever `bus_rd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on domain reset, active low; the only reset of the flags |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bit 23 is the clear command |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_rd` is high |
| cfg_cmd_secure | input | 1 | Command bit is secure |
| cfg_priv_sec | input | 1 | Privilege is required while the bit is secure |
| cfg_priv_nsec | input | 1 | Privilege is required while the bit is non-secure |
| src_pulse | input | 7 | One pulse per reset source |

## Verification
A wrong flag state shows at `bus_rdata` on the first read after the cycle in which it went wrong. A dropped set, a missed clear, or a clear that was wrongly accepted is therefore visible one clock after the pulse or write that caused it. Gate errors show only through the flags, because a rejected access produces no other signal. For that reason each access case is tested by first setting flags and then reading them back after the write.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int NSRC     = 7,
  parameter int DW       = 32,
  parameter int CMD_BIT  = 23,
  parameter int FLAG_LSB = 25
) (
  input  logic            clk,
  input  logic            por_rst_n,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_secure,
  input  logic            bus_priv,
  output logic [DW-1:0]   bus_rdata,
  input  logic            cfg_cmd_secure,
  input  logic            cfg_priv_sec,
  input  logic            cfg_priv_nsec,
  input  logic [NSRC-1:0] src_pulse
);

  localparam int FLAG_MSB = FLAG_LSB + NSRC - 1;

  logic [NSRC-1:0] flags;
  logic            cmd_ok;
  logic            clr;
  logic [DW-1:0]   word;

  assign cmd_ok = cfg_cmd_secure ? (bus_secure && (!cfg_priv_sec || bus_priv))
                                 : (!cfg_priv_nsec || bus_priv);
  assign clr    = bus_wr && bus_wdata[CMD_BIT] && cmd_ok;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) flags <= '0;
    else            flags <= (clr ? '0 : flags) | src_pulse;
  end

  always_comb begin
    word = '0;
    word[FLAG_MSB:FLAG_LSB] = flags;
  end

  assign bus_rdata = bus_rd ? word : '0;

  p_set_r2: assert property (@(posedge clk) disable iff (!por_rst_n)
    1'b1 |=> ((flags & $past(src_pulse)) == $past(src_pulse)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!por_rst_n)
    clr |=> (flags == $past(src_pulse)));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!por_rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  p_reject_r5: assert property (@(posedge clk) disable iff (!por_rst_n)
    (bus_wr && bus_wdata[CMD_BIT] && cfg_cmd_secure && !bus_secure)
      |=> (flags == ($past(flags) | $past(src_pulse))));

  p_priv_r6: assert property (@(posedge clk) disable iff (!por_rst_n)
    (bus_wr && bus_wdata[CMD_BIT] && !bus_priv &&
     (cfg_cmd_secure ? cfg_priv_sec : cfg_priv_nsec))
      |=> (flags == ($past(flags) | $past(src_pulse))));

endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  logic        clk = 1'b0;
  logic        por_rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_secure = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic        cfg_cmd_secure = 1'b0, cfg_priv_sec = 1'b0, cfg_priv_nsec = 1'b0;
  logic [6:0]  src_pulse = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .por_rst_n(por_rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .cfg_cmd_secure(cfg_cmd_secure),
    .cfg_priv_sec(cfg_priv_sec), .cfg_priv_nsec(cfg_priv_nsec),
    .src_pulse(src_pulse));

  function automatic logic [31:0] expw(input logic [6:0] f);
    return {f, 25'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic sec, input logic priv,
                          input logic [6:0] f);
    @(negedge clk);
    bus_rd = 1'b1; bus_secure = sec; bus_priv = priv;
    #1 check(req, bus_rdata, expw(f));
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    src_pulse = p;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic wr(input logic [31:0] d, input logic sec, input logic priv);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d; bus_secure = sec; bus_priv = priv;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset;
    check("R1 reset read", 32'(i_rst_cause_reg.bus_rdata), 32'h0);
    rd_check("R1 flags zero", 1'b0, 1'b0, 7'h00);
  endtask

  task automatic t_set;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      rd_check("R2 single source", 1'b0, 1'b0, 7'((2 << i) - 1));
    end
    @(negedge clk);
    check("R8 idle rdata zero", bus_rdata, 32'h0);
  endtask

  task automatic t_clear;
    wr(32'hFF7F_FFFF, 1'b0, 1'b0);
    rd_check("R3 write bit23=0 no effect", 1'b0, 1'b0, 7'h7F);
    rd_check("R7 unused bits zero, any access", 1'b1, 1'b1, 7'h7F);
    wr(32'h0080_0000, 1'b0, 1'b0);
    rd_check("R3 clear all", 1'b0, 1'b0, 7'h00);
  endtask

  task automatic t_same_cycle;
    pulse(7'h41);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 32'h0080_0000; src_pulse = 7'h04; bus_rd = 1'b1;
    #1 check("R8 read during clear shows old", bus_rdata, expw(7'h41));
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; src_pulse = '0; bus_rd = 1'b0;
    rd_check("R4 pulse beats clear", 1'b0, 1'b0, 7'h04);
    pulse(7'h10);
    rd_check("R4 sticky accumulate", 1'b0, 1'b0, 7'h14);
  endtask

  task automatic t_secure;
    cfg_cmd_secure = 1'b1;
    wr(32'h0080_0000, 1'b0, 1'b1);
    rd_check("R5 nonsecure clear ignored", 1'b0, 1'b0, 7'h14);
    wr(32'h0080_0000, 1'b1, 1'b0);
    rd_check("R5 secure clear accepted", 1'b0, 1'b0, 7'h00);
  endtask

  task automatic t_priv;
    pulse(7'h22);
    cfg_cmd_secure = 1'b1; cfg_priv_sec = 1'b1;
    wr(32'h0080_0000, 1'b1, 1'b0);
    rd_check("R6 secure unprivileged ignored", 1'b0, 1'b0, 7'h22);
    wr(32'h0080_0000, 1'b1, 1'b1);
    rd_check("R6 secure privileged accepted", 1'b0, 1'b0, 7'h00);
    pulse(7'h08);
    cfg_cmd_secure = 1'b0; cfg_priv_sec = 1'b0; cfg_priv_nsec = 1'b1;
    wr(32'h0080_0000, 1'b0, 1'b0);
    rd_check("R6 nonsecure unprivileged ignored", 1'b0, 1'b0, 7'h08);
    cfg_priv_nsec = 1'b0; cfg_priv_sec = 1'b1;
    wr(32'h0080_0000, 1'b0, 1'b0);
    rd_check("R6 secure-priv setting not applied to nonsecure bit", 1'b0, 1'b0, 7'h00);
  endtask

  task automatic t_por;
    pulse(7'h7F);
    @(negedge clk);
    por_rst_n = 1'b0;
    @(negedge clk);
    por_rst_n = 1'b1;
    rd_check("R1 power-on reset clears", 1'b0, 1'b0, 7'h00);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    t_reset();
    t_set();
    t_clear();
    t_same_cycle();
    t_secure();
    t_priv();
    t_por();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule